// File: doc/BRIEF.md
# Line Clamp Pulse Timing Generator

This block generates the once-per-line clamp strobe for a video digitizer front end. It runs on the pixel clock. A horizontal sync input is synchronized, and its trailing edge marks the start of the back porch. The block then counts a programmable number of pixel periods as a placement delay, and raises the clamp strobe for a programmable number of pixel periods. A mode bit can replace this internal timing with an external clamp input of either polarity. The block also drives the clamp target code for each colour channel. Red and blue can each be set to bottom or midscale. Green is always bottom.

Settings are loaded through a plain write port with an enable, an address and a data byte. The placement and duration values are staged when they are written. They are copied into the working set only at a sync trailing edge, so a window already in progress keeps the timing it started with. The block has no data stream, so every pin is plain control with no handshake.

Top module: `line_clamp_gen`

## Requirements
- R1: After reset, clamp_out is low, all three target codes are 0x00, placement is 8, duration is 20 (0x14), internal timing is selected and sync is treated as active high.
- R2: With the sync polarity bit (control bit 2) at 0, a high-to-low hsync_in change is the trailing edge. With the bit at 1, a low-to-high change is the trailing edge. The opposite change, the leading edge, never starts a window.
- R3: If hsync_in changes to its trailing level just before rising clock edge 1, then with placement P and duration D, clamp_out is high after rising edges P+3 through P+2+D and low otherwise.
- R4: With placement 0, clamp_out is high from the third rising edge after the hsync change.
- R5: With duration 0, no clamp pulse appears on that line.
- R6: A trailing edge that arrives while a window is in its placement or clamp phase drops the strobe and restarts the placement count, using the staged values.
- R7: A write to placement (address 0) or duration (address 1) does not change the window in progress. It applies from the next trailing edge.
- R8: When control bit 0 (external mode) is 1, clamp_out follows ext_clamp_in combinationally. Control bit 1 selects the polarity: 1 means active high, 0 means active low. The control register is at address 2 and takes effect at the clock edge that writes it.
- R9: Control bit 3 sets code_red to 0x80 (1) or 0x00 (0). Control bit 4 does the same for code_blu. code_grn is always 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp request |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address: 0 placement, 1 duration, 2 control |
| cfg_wdata | input | 8 | Register write data |
| clamp_out | output | 1 | Clamp strobe |
| code_red | output | 8 | Red clamp target code |
| code_grn | output | 8 | Green clamp target code |
| code_blu | output | 8 | Blue clamp target code |

## Verification
An hsync change passes through two synchronizer flops and one edge-detect flop, so the first clamp cycle shows up after rising edge P+3 counted from the change. The bench drives hsync on a falling edge, then samples clamp_out on every later falling edge and compares it with a window of P+3 to P+2+D computed from the requirement. Writes to the target codes and the control register are checked at the falling edge after the writing edge. The external path is combinational, so it is checked a short delay after ext_clamp_in is driven.

// File: rtl/line_clamp_pkg.sv
package line_clamp_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_WAIT  = 2'd1,
    WIN_CLAMP = 2'd2
  } win_state_t;

  localparam int unsigned ADR_PLACE = 0;
  localparam int unsigned ADR_DUR   = 1;
  localparam int unsigned ADR_CTRL  = 2;

  localparam int unsigned CB_EXT_MODE = 0;
  localparam int unsigned CB_EXT_POL  = 1;
  localparam int unsigned CB_SYNC_POL = 2;
  localparam int unsigned CB_RED_MID  = 3;
  localparam int unsigned CB_BLU_MID  = 4;
  localparam int unsigned CTRL_W      = 5;
endpackage

// File: rtl/lc_sync_edge.sv
module lc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_async,
  input  logic sync_active_low,
  output logic trail_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= hsync_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // trailing edge: was active, now inactive
  assign trail_o = (s3_q ^ sync_active_low) & ~(s2_q ^ sync_active_low);
endmodule

// File: rtl/lc_cfg_regs.sv
module lc_cfg_regs
  import line_clamp_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned PLACE_RST = 8,
  parameter int unsigned DUR_RST   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              trail_i,
  output logic [CNT_W-1:0]  plc_o,
  output logic [CNT_W-1:0]  dur_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CNT_W-1:0]  plc_stg, dur_stg, plc_act, dur_act;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plc_stg <= CNT_W'(PLACE_RST);
      dur_stg <= CNT_W'(DUR_RST);
      ctrl_q  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADR_PLACE)) plc_stg <= wdata;
      if (addr == ADDR_W'(ADR_DUR))   dur_stg <= wdata;
      if (addr == ADDR_W'(ADR_CTRL))  ctrl_q  <= wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plc_act <= CNT_W'(PLACE_RST);
      dur_act <= CNT_W'(DUR_RST);
    end else if (trail_i) begin
      plc_act <= plc_stg;
      dur_act <= dur_stg;
    end
  end

  // at a trailing edge the counter loads the staged values directly
  assign plc_o  = trail_i ? plc_stg : plc_act;
  assign dur_o  = trail_i ? dur_stg : dur_act;
  assign ctrl_o = ctrl_q;

  // R7
  working_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trail_i |=> ($stable(plc_act) && $stable(dur_act)));
endmodule

// File: rtl/lc_window_ctr.sv
module lc_window_ctr
  import line_clamp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail_i,
  input  logic [CNT_W-1:0] plc_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             clamp_o
);
  win_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else if (trail_i) begin
      if (plc_i != '0) begin
        state_q <= WIN_WAIT;
        cnt_q   <= plc_i;
      end else if (dur_i != '0) begin
        state_q <= WIN_CLAMP;
        cnt_q   <= dur_i;
      end else begin
        state_q <= WIN_IDLE;
        cnt_q   <= '0;
      end
    end else begin
      case (state_q)
        WIN_WAIT: begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= (dur_i != '0) ? WIN_CLAMP : WIN_IDLE;
            cnt_q   <= dur_i;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        WIN_CLAMP: begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          state_q <= WIN_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign clamp_o = (state_q == WIN_CLAMP);

  // R6
  restart_drops_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_i && plc_i != '0) |=> !clamp_o);
  // R4
  zero_place_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_i && plc_i == '0 && dur_i != '0) |=> clamp_o);
  // R5
  zero_dur_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_i && dur_i == '0) |=> !clamp_o);
  // R3
  strobe_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_o && !trail_i && cnt_q == CNT_W'(1)) |=> !clamp_o);
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import line_clamp_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned PLACE_RST = 8,
  parameter int unsigned DUR_RST   = 20
) (
  input  logic              clk_pix,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              ext_clamp_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              clamp_out,
  output logic [CODE_W-1:0] code_red,
  output logic [CODE_W-1:0] code_grn,
  output logic [CODE_W-1:0] code_blu
);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_BOT = '0;

  logic              trail;
  logic [CNT_W-1:0]  plc_eff, dur_eff;
  logic [CTRL_W-1:0] ctrl;
  logic              int_clamp;

  lc_sync_edge i_sync (
    .clk            (clk_pix),
    .rst_n          (rst_n),
    .hsync_async    (hsync_in),
    .sync_active_low(ctrl[CB_SYNC_POL]),
    .trail_o        (trail)
  );

  lc_cfg_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PLACE_RST(PLACE_RST), .DUR_RST(DUR_RST)
  ) i_regs (
    .clk    (clk_pix),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .trail_i(trail),
    .plc_o  (plc_eff),
    .dur_o  (dur_eff),
    .ctrl_o (ctrl)
  );

  lc_window_ctr #(.CNT_W(CNT_W)) i_win (
    .clk    (clk_pix),
    .rst_n  (rst_n),
    .trail_i(trail),
    .plc_i  (plc_eff),
    .dur_i  (dur_eff),
    .clamp_o(int_clamp)
  );

  always_comb begin
    if (ctrl[CB_EXT_MODE])
      clamp_out = ctrl[CB_EXT_POL] ? ext_clamp_in : ~ext_clamp_in;
    else
      clamp_out = int_clamp;
  end

  assign code_red = ctrl[CB_RED_MID] ? CODE_MID : CODE_BOT;
  assign code_blu = ctrl[CB_BLU_MID] ? CODE_MID : CODE_BOT;
  assign code_grn = CODE_BOT;

  // R8
  internal_path_chk: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !ctrl[CB_EXT_MODE] |-> (clamp_out == int_clamp));
endmodule

// File: tb/test_line_clamp_gen.sv
module test_line_clamp_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_pix = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       ext_clamp_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       clamp_out;
  logic [7:0] code_red, code_grn, code_blu;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_pix = ~clk_pix;

  line_clamp_gen i_line_clamp_gen (
    .clk_pix(clk_pix), .rst_n(rst_n), .hsync_in(hsync_in),
    .ext_clamp_in(ext_clamp_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .clamp_out(clamp_out), .code_red(code_red),
    .code_grn(code_grn), .code_blu(code_blu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_pix);
    @(negedge clk_pix);
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // one line: leading edge, hold, trailing edge, then check every cycle
  task automatic run_line(input string req, input int p, input int d,
                          input logic act_lvl, input int len);
    hsync_in = act_lvl;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk({req, " R2 leading edge idle"}, {7'b0, clamp_out}, 8'h00);
    end
    hsync_in = ~act_lvl;
    for (int n = 1; n <= len; n++) begin
      tick();
      chk(req, {7'b0, clamp_out}, {7'b0, (n >= p + 3 && n <= p + 2 + d)});
    end
  endtask

  task automatic t_reset();
    chk("R1 clamp", {7'b0, clamp_out}, 8'h00);
    chk("R1 red", code_red, 8'h00);
    chk("R1 grn", code_grn, 8'h00);
    chk("R1 blu", code_blu, 8'h00);
    run_line("R1 default window R3", 8, 20, 1'b1, 36);
  endtask

  task automatic t_short();
    cfg_wr(2'd0, 8'd3);
    cfg_wr(2'd1, 8'd4);
    run_line("R3 P3 D4", 3, 4, 1'b1, 14);
    cfg_wr(2'd0, 8'd0);
    run_line("R4 P0 D4", 0, 4, 1'b1, 10);
    cfg_wr(2'd1, 8'd0);
    run_line("R5 D0 P0", 0, 0, 1'b1, 8);
    cfg_wr(2'd0, 8'd5);
    run_line("R5 D0 P5", 5, 0, 1'b1, 14);
  endtask

  task automatic t_restart();
    cfg_wr(2'd0, 8'd2);
    cfg_wr(2'd1, 8'd10);
    hsync_in = 1'b1;
    repeat (6) tick();
    hsync_in = 1'b0;
    for (int n = 1; n <= 26; n++) begin
      logic e;
      tick();
      e = (n >= 5 && n <= 10) || (n >= 13 && n <= 22);
      chk("R6 restart", {7'b0, clamp_out}, {7'b0, e});
      if (n == 6) hsync_in = 1'b1;
      if (n == 8) hsync_in = 1'b0;
    end
  endtask

  task automatic t_deferred();
    hsync_in = 1'b1;
    repeat (6) tick();
    hsync_in = 1'b0;
    for (int n = 1; n <= 18; n++) begin
      tick();
      chk("R7 current line kept", {7'b0, clamp_out}, {7'b0, (n >= 5 && n <= 14)});
      if (n == 4) begin cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'd3; end
      if (n == 5) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'd1; end
      if (n == 6) cfg_we = 1'b0;
    end
    run_line("R7 next line new", 1, 3, 1'b1, 10);
  endtask

  task automatic t_sync_pol();
    cfg_wr(2'd2, 8'h04);
    run_line("R2 active-low sync", 1, 3, 1'b0, 10);
    cfg_wr(2'd2, 8'h00);
    hsync_in = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_ext();
    cfg_wr(2'd2, 8'h03);
    ext_clamp_in = 1'b1; #1;
    chk("R8 ext high pol", {7'b0, clamp_out}, 8'h01);
    ext_clamp_in = 1'b0; #1;
    chk("R8 ext high pol", {7'b0, clamp_out}, 8'h00);
    @(negedge clk_pix);
    cfg_wr(2'd2, 8'h01);
    chk("R8 ext low pol", {7'b0, clamp_out}, 8'h01);
    ext_clamp_in = 1'b1; #1;
    chk("R8 ext low pol", {7'b0, clamp_out}, 8'h00);
    @(negedge clk_pix);
    run_line("R8 timer masked", 99, 0, 1'b1, 8);
    cfg_wr(2'd2, 8'h00);
    ext_clamp_in = 1'b0;
    chk("R8 back to internal", {7'b0, clamp_out}, 8'h00);
  endtask

  task automatic t_codes();
    cfg_wr(2'd2, 8'h08);
    chk("R9 red mid", code_red, 8'h80);
    chk("R9 blu bot", code_blu, 8'h00);
    chk("R9 grn bot", code_grn, 8'h00);
    cfg_wr(2'd2, 8'h10);
    chk("R9 red bot", code_red, 8'h00);
    chk("R9 blu mid", code_blu, 8'h80);
    cfg_wr(2'd2, 8'h18);
    chk("R9 both red", code_red, 8'h80);
    chk("R9 both blu", code_blu, 8'h80);
    chk("R9 grn fixed", code_grn, 8'h00);
    cfg_wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_pix);
    rst_n = 1'b1;
    @(negedge clk_pix);
    t_reset();
    t_short();
    t_restart();
    t_deferred();
    t_sync_pol();
    t_ext();
    t_codes();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule